// File: doc/BRIEF.md
# Presettable Synchronous Decade Counter

The block is a 4-bit synchronous counter that steps through the BCD digits 0 to 9. A parameter can switch it to a plain modulo-16 binary counter instead. The counter can be cleared, can take a preset value from a parallel data input, can count up, or can hold its value. One fixed precedence decides which of these happens. A second parameter chooses how the active-low reset behaves. In the synchronous form the reset takes effect on a clock edge. In the asynchronous form it takes effect at once.

Two active-high count enables gate the increment. Only the trickle enable takes part in the terminal-count output. This lets a chain of stages pass the carry from one digit to the next: the terminal count of a lower stage drives the trickle enable of the stage above it. A common parallel enable goes to every stage.

Top module: `decade_counter`

## Requirements
- R1: With the default synchronous reset, a low `rst_n` sampled on a rising edge of `clk` makes `q` equal 0 after that edge. This overrides load and count.
- R2: With `ASYNC_RESET=1`, a low `rst_n` forces `q` to 0 at once, before any clock edge, whatever the other inputs are.
- R3: When reset is inactive and `load_n` is low, `q` takes the value of `din` on the next rising edge, even if both count enables are high.
- R4: When reset is inactive, `load_n` is high and both `en_p` and `en_t` are high, `q` advances by one each edge. In decade mode (`DECADE=1`) the step after 9 is 0.
- R5: When reset is inactive and `load_n` is high, a low on `en_p` or on `en_t` leaves `q` unchanged.
- R6: In binary mode (`DECADE=0`) the count runs modulo-16, and the step after 15 is 0.
- R7: `tc` is high exactly when `en_t` is high and `q` is at its top value: 9 in decade mode, 15 in binary mode. `load_n`, `en_p` and `din` have no effect on `tc`.
- R8: In decade mode, a loaded value from 10 to 15 goes up by one on each count edge. The step after 15 is 0.
- R9: Two decade stages chained (`tc` of the low stage into `en_t` of the high stage) count from 00 to 99 and then wrap to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; synchronous or asynchronous, chosen by `ASYNC_RESET` |
| load_n | input | 1 | Active-low parallel preset enable |
| din | input | WIDTH | Preset value |
| en_p | input | 1 | Count enable that does not affect `tc` |
| en_t | input | 1 | Count enable that also gates `tc` |
| q | output | WIDTH | Present count |
| tc | output | 1 | Terminal-count flag used for cascading |

## Verification
The bench chains two decade stages through the whole range 00 to 99 and the wrap back to 00. A carry into the high digit that comes one edge early or late, or a high digit that moves while the low digit holds, shows up here as a wrong two-digit value. It drives conflicting controls together: reset with load, and load with both enables high. A design with the wrong precedence would preset instead of clearing, or count instead of loading. It loads values from 10 to 15 into a decade stage. A design that wrapped at 9 by comparing with a greater-or-equal test would jump straight to 0 instead of climbing to 15 first. It also checks that dropping only the trickle enable clears `tc`, and that changing `load_n` does not. It asserts reset in the middle of a cycle on an asynchronous instance, which catches a reset that waits for the clock.

// File: rtl/decade_counter_pkg.sv
// Shared types for the decade counter: the four operating modes,
// listed from highest to lowest precedence.
package decade_counter_pkg;
    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_COUNT = 2'd2,
        MODE_HOLD  = 2'd3
    } ctr_mode_e;
endpackage

// File: rtl/ctr_mode_sel.sv
// Mode selector: turns the control inputs into one operating mode.
// Precedence is clear, then load, then count, then hold.
// Assumes clr_req is already active-high and only set when the
// clear is meant to act on a clock edge.
module ctr_mode_sel
    import decade_counter_pkg::*;
(
    input  logic      clr_req,
    input  logic      load_n,
    input  logic      en_p,
    input  logic      en_t,
    output ctr_mode_e mode
);
    // Priority decode of the four modes.
    always_comb begin
        if (clr_req)
            mode = MODE_CLEAR;
        else if (!load_n)
            mode = MODE_LOAD;
        else if (en_p && en_t)
            mode = MODE_COUNT;
        else
            mode = MODE_HOLD;
    end
endmodule

// File: rtl/ctr_next.sv
// Next-state logic: works out the count value for the next edge from the
// selected mode. LAST is the top value of the counting range. Values
// above LAST (possible only after a preset) go up by one, and the
// WIDTH-bit sum wraps them to zero after all ones.
module ctr_next
    import decade_counter_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter logic [WIDTH-1:0] LAST = 4'd9
) (
    input  ctr_mode_e        mode,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] inc;

    // Increment with the wrap at the top of the range.
    always_comb begin
        if (cur == LAST)
            inc = '0;
        else
            inc = cur + ONE;
    end

    // Choose the next value from the mode.
    always_comb begin
        unique case (mode)
            MODE_CLEAR: nxt = '0;
            MODE_LOAD:  nxt = din;
            MODE_COUNT: nxt = inc;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_term.sv
// Terminal-count decode: high when the trickle enable is high and the
// count sits at the top of its range. Purely combinational, so a carry
// passes through a chain of stages within one cycle.
module ctr_term #(
    parameter int unsigned WIDTH = 4,
    parameter logic [WIDTH-1:0] LAST = 4'd9
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_t,
    output logic             tc
);
    // Flag the top value, gated by the trickle enable.
    always_comb tc = en_t && (cur == LAST);
endmodule

// File: rtl/decade_counter.sv
// Presettable synchronous counter, one digit wide.
// DECADE=1 counts 0..9; DECADE=0 counts over the full WIDTH-bit range.
// ASYNC_RESET=0 (the default) clears on a clock edge; ASYNC_RESET=1
// clears as soon as rst_n falls. Stages are chained by feeding tc into
// the en_t input of the next stage.
module decade_counter
    import decade_counter_pkg::*;
#(
    parameter int unsigned WIDTH       = 4,
    parameter bit          DECADE      = 1'b1,
    parameter bit          ASYNC_RESET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_p,
    input  logic             en_t,
    output logic [WIDTH-1:0] q,
    output logic             tc
);
    localparam logic [WIDTH-1:0] LAST = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

    ctr_mode_e        mode;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] cnt_q;
    logic             clr_req;

    // The clear goes through the mode decode only in the synchronous form.
    always_comb clr_req = ASYNC_RESET ? 1'b0 : ~rst_n;

    ctr_mode_sel u_mode (
        .clr_req (clr_req),
        .load_n  (load_n),
        .en_p    (en_p),
        .en_t    (en_t),
        .mode    (mode)
    );

    ctr_next #(.WIDTH(WIDTH), .LAST(LAST)) u_next (
        .mode (mode),
        .cur  (cnt_q),
        .din  (din),
        .nxt  (nxt)
    );

    ctr_term #(.WIDTH(WIDTH), .LAST(LAST)) u_term (
        .cur  (cnt_q),
        .en_t (en_t),
        .tc   (tc)
    );

    generate
        if (ASYNC_RESET) begin : g_async_rst
            // Count register, cleared at once by a low rst_n.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt_q <= '0;
                else
                    cnt_q <= nxt;
            end
        end else begin : g_sync_rst
            // Count register; the clear arrives through the mode decode.
            always_ff @(posedge clk) begin
                cnt_q <= nxt;
            end
        end
    endgenerate

    always_comb q = cnt_q;
endmodule

// File: rtl/decade_counter_chk.sv
// Property checker for decade_counter, attached with a bind.
// It watches only the ports and checks the mode precedence over time.
module decade_counter_chk #(
    parameter int unsigned WIDTH       = 4,
    parameter bit          DECADE      = 1'b1,
    parameter bit          ASYNC_RESET = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             en_p,
    input logic             en_t,
    input logic [WIDTH-1:0] q,
    input logic             tc
);
    localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] INC = WIDTH'(1);

    // R1: reset seen on an edge leaves the count at zero.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    generate
        if (ASYNC_RESET) begin : g_async
            // R2: while reset is low the count is already zero at every edge.
            assert_async_zero_R2: assert property (@(posedge clk)
                !rst_n |-> (q == '0));
        end
    endgenerate

    // R3: a load takes the preset value.
    assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (q == $past(din)));

    // R4: counting steps by one, wrapping after the top value.
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_p && en_t) |=>
            (q == (($past(q) == TOP) ? '0 : $past(q) + INC)));

    // R5: either enable low keeps the count still.
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(en_p && en_t)) |=> $stable(q));

    // R7: a terminal count needs the trickle enable and the top value.
    assert_tc_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (en_t && (q == TOP)));
endmodule

bind decade_counter decade_counter_chk #(
    .WIDTH(WIDTH), .DECADE(DECADE), .ASYNC_RESET(ASYNC_RESET)
) u_chk (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q), .tc(tc)
);

// File: tb/tb_decade_counter.sv
// Bench: two chained decade stages, a binary instance and an asynchronous
// reset instance, each compared on every clock with a behavioural model.
module tb_decade_counter;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic       rst_n = 1'b0, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
    logic [3:0] din = 4'd0, din_hi = 4'd0;
    logic [3:0] q_lo, q_hi, q_bin, q_as;
    logic       tc_lo, tc_hi, tc_bin, tc_as;

    decade_counter dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q_lo), .tc(tc_lo));
    decade_counter dut_hi (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din_hi),
        .en_p(en_p), .en_t(tc_lo), .q(q_hi), .tc(tc_hi));
    decade_counter #(.DECADE(1'b0)) dut_bin (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q_bin), .tc(tc_bin));
    decade_counter #(.ASYNC_RESET(1'b1)) dut_async (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q_as), .tc(tc_as));

    int compared = 0, mismatched = 0;
    int m_lo = 0, m_hi = 0, m_bin = 0, m_as = 0;
    string tag = "R1";

    function automatic int step(int cur, bit rs, bit ld, int d, bit ep, bit et, bit dec);
        if (!rs) return 0;
        if (!ld) return d;
        if (ep && et) begin
            if (dec && cur == 9) return 0;
            return (cur + 1) % 16;
        end
        return cur;
    endfunction

    function automatic bit term(int cur, bit et, bit dec);
        return et && (cur == (dec ? 9 : 15));
    endfunction

    task automatic check(int act, int exp, string what);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock cycle: drive at the falling edge, compare after the rising edge.
    task automatic cyc(bit rs, bit ld, int d, int dh, bit ep, bit et);
        int n_lo, n_hi, n_bin, n_as;
        @(negedge clk);
        rst_n = rs; load_n = ld; din = 4'(d); din_hi = 4'(dh); en_p = ep; en_t = et;
        #1;
        if (!rs) begin
            m_as = 0;
            check(int'(q_as), 0, "R2 async q before edge");
        end
        n_lo  = step(m_lo, rs, ld, d, ep, et, 1'b1);
        n_hi  = step(m_hi, rs, ld, dh, ep, term(m_lo, et, 1'b1), 1'b1);
        n_bin = step(m_bin, rs, ld, d, ep, et, 1'b0);
        n_as  = step(m_as, rs, ld, d, ep, et, 1'b1);
        @(posedge clk);
        #1;
        m_lo = n_lo; m_hi = n_hi; m_bin = n_bin; m_as = n_as;
        check(int'(q_lo), m_lo, "low q");
        check(int'(q_hi), m_hi, "high q");
        check(int'(q_bin), m_bin, "binary q");
        check(int'(q_as), m_as, "async q");
        check(int'(tc_lo), int'(term(m_lo, et, 1'b1)), "low tc");
        check(int'(tc_hi), int'(term(m_hi, term(m_lo, et, 1'b1), 1'b1)), "high tc");
        check(int'(tc_bin), int'(term(m_bin, et, 1'b0)), "binary tc");
    endtask

    initial begin
        fork
            begin
                // R1: reset together with a load and both enables high
                tag = "R1";
                repeat (3) cyc(0, 0, 5, 6, 1, 1);
                // R9 with R4, R6, R7: run the chain through 00..99, wrap to 00
                tag = "R9 R4 R6 R7";
                for (int i = 0; i < 104; i++) cyc(1, 1, 0, 0, 1, 1);
                // R5: parallel enable low, then trickle enable low
                tag = "R5";
                for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, 1);
                tag = "R5 R7";
                for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 1, 0);
                // R3: load overrides count
                tag = "R3";
                cyc(1, 0, 7, 3, 1, 1);
                cyc(1, 0, 2, 8, 1, 1);
                // R7: top value with load_n low keeps tc; en_t low clears it
                tag = "R7";
                cyc(1, 0, 9, 9, 0, 1);
                cyc(1, 0, 9, 9, 1, 1);
                cyc(1, 1, 9, 9, 0, 1);
                cyc(1, 1, 9, 9, 0, 0);
                cyc(1, 0, 15, 0, 0, 1);
                cyc(1, 1, 0, 0, 0, 1);
                // R8 and R6: preset 12, climb through 15 back to 0
                tag = "R8 R6";
                cyc(1, 0, 12, 10, 0, 0);
                for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 1, 1);
                // R1 with R2: reset in mid-count with a load pending
                tag = "R1 R2";
                cyc(1, 0, 4, 4, 1, 1);
                cyc(0, 0, 8, 8, 1, 1);
                cyc(1, 1, 0, 0, 1, 1);
                tag = "R4";
                for (int i = 0; i < 12; i++) cyc(1, 1, 0, 0, 1, 1);
            end
            begin
                repeat (5000) @(posedge clk);
                mismatched++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule